// File: doc/BRIEF.md
# Mailbox Transfer Sequencer

This block acts as a host-side hardware master for a byte mailbox. The mailbox has a data address and a command/status address. The sequencer takes a request held in a byte buffer and pushes it through the mailbox. It then pulls the reply back into a second byte buffer. It reports either the reply length or a reason for failure. The I/O port is single-cycle: a read strobe returns its data in the same cycle, and a write strobe commits at the clock edge.

A transfer starts when the sequencer writes a cancel command, which recovers a mailbox that may have stalled after back-to-back commands. It then waits for ready, draining any stale output byte it finds along the way. It opens the request with a normal-mode command, feeds the request bytes one at a time as the input buffer frees, and closes the request with an end command.

On receive, the sequencer checks the start marker and streams reply bytes until the mailbox flags the end marker. It then takes the reply length from the big-endian field held in reply bytes 2 through 5. Every status wait has its own programmable timeout.

Top module: `mbx_xfer_seq`

## Requirements
- R1: After reset, `done`, `io_rd`, `io_wr` and `rsp_we` are low and `err_code` is 0.
- R2: A start from idle first writes 0x22 to the command address on the following cycle. The sequencer then waits for status bit 4 (ready), then waits for status bit 1 (input full) to clear, then writes 0x01 to the command address, then waits for status bit 5 (input ready).
- R3: Request bytes 0 to `req_len`-1 go to the data address in order. Each byte is written only after a status read shows bit 1 clear. A zero-length request writes no data.
- R4: After the last request byte, the sequencer waits once more for bit 1 clear and then writes 0x03 to the command address. Only three command values are ever written: 0x22, 0x01 and 0x03.
- R5: Receive waits for status bit 2 (frame flag), then reads the data address. Any value other than 0x01 ends the transfer with code 2.
- R6: For each reply byte, the sequencer waits for status bit 0 (output full). If bit 2 is set in that same status, collection stops. Otherwise the data byte is read and stored at the next response buffer address, starting from 0.
- R7: When collection stops, the next data read must be 0x03, or the transfer ends with code 4. If the buffer fills to `rsp_cap` bytes before the frame flag appears, the transfer ends with code 3.
- R8: A start with `rsp_cap` below 6 ends on the next cycle with code 6 and performs no I/O.
- R9: A length field (bytes 2..5, most significant byte first) greater than `rsp_cap` ends with code 5. Otherwise the transfer ends with code 0, and `rsp_len` shows the field. A field equal to the capacity is accepted.
- R10: Each status wait reloads the timeout. A wait that sees `timeout_cycles`+1 non-matching status reads in a row ends with code 1.
- R11: During the ready wait, a status with bit 0 set causes a data read that drains the stale byte, and the status is then polled again.
- R12: `done` is high for exactly one cycle per transfer. A start seen while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| req_len | input | LW | Number of request bytes |
| rsp_cap | input | LW | Response buffer capacity in bytes |
| timeout_cycles | input | TW | Allowed failed polls per status wait |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last transfer ended with an error |
| err_code | output | 3 | 0 ok, 1 timeout, 2 bad start marker, 3 missing frame flag, 4 bad end marker, 5 length overflow, 6 capacity too small |
| rsp_len | output | 32 | Reply length from the last successful transfer |
| req_addr | output | LW | Request buffer read address |
| req_data | input | 8 | Request byte at `req_addr` (same cycle) |
| rsp_we | output | 1 | Response buffer write strobe |
| rsp_addr | output | LW | Response buffer write address |
| rsp_wdata | output | 8 | Response byte |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_sel | output | 1 | 0 data address, 1 command/status address |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data (same cycle as `io_rd`) |

## Verification
The bench drives a behavioural mailbox that holds its input-full flag for several cycles after each data write. With a timeout shorter than the total hold time but longer than one hold, a sequencer that failed to reload its timer per wait would time out in mid-request. Stale output bytes sit in the mailbox before ready rises; a design that ignored them would either hang until timeout or leave them undrained. Reply frames with a wrong start marker, a wrong end marker, no end flag within capacity, and a length one above, or equal to, the capacity each have to produce their own code. A sequencer that wrote a byte while the input was still full, or that kept collecting past the capacity, is caught by the model's protocol monitor.

// File: rtl/mbx_xfer_seq.sv
module mbx_xfer_seq #(
  parameter int LW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] req_len,
  input  logic [LW-1:0] rsp_cap,
  input  logic [TW-1:0] timeout_cycles,
  output logic          done,
  output logic          fail,
  output logic [2:0]    err_code,
  output logic [31:0]   rsp_len,
  output logic [LW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          rsp_we,
  output logic [LW-1:0] rsp_addr,
  output logic [7:0]    rsp_wdata,
  output logic          io_rd,
  output logic          io_wr,
  output logic          io_sel,
  output logic [7:0]    io_wdata,
  input  logic [7:0]    io_rdata
);

  localparam logic [7:0] B_OBF = 8'h01;
  localparam logic [7:0] B_IBF = 8'h02;
  localparam logic [7:0] B_F0  = 8'h04;
  localparam logic [7:0] B_IBR = 8'h20;
  localparam logic [7:0] C_CANCEL = 8'h22;
  localparam logic [7:0] C_NORMAL = 8'h01;
  localparam logic [7:0] C_END    = 8'h03;
  localparam logic [2:0] E_OK = 3'd0, E_TMO = 3'd1, E_START = 3'd2, E_NOF0 = 3'd3,
                         E_END = 3'd4, E_OVF = 3'd5, E_SMALL = 3'd6;
  localparam logic [LW-1:0] MIN_CAP = LW'(6);

  typedef enum logic [3:0] {
    S_IDLE, S_CANCEL, S_RDY, S_DRAIN, S_POLL, S_NORMAL, S_NEXT,
    S_WRB, S_EOC, S_START, S_COLLECT, S_RDB, S_ENDM
  } st_t;

  st_t           st, pret;
  logic [TW-1:0] tmr;
  logic [LW-1:0] idx;
  logic [31:0]   len_q, rsp_len_q;
  logic [7:0]    sts_q, pmask, pval;
  logic [2:0]    code_q;
  logic          done_q;

  always_comb begin
    pmask = B_IBF;
    pval  = 8'h00;
    case (pret)
      S_NEXT:    begin pmask = B_IBR; pval = B_IBR; end
      S_START:   begin pmask = B_F0;  pval = B_F0;  end
      S_COLLECT: begin pmask = B_OBF; pval = B_OBF; end
      default:   ;
    endcase
  end

  logic poll_hit, rdy_hit, last_slot, len_byte;
  assign poll_hit  = (io_rdata & pmask) == pval;
  assign rdy_hit   = !io_rdata[0] && io_rdata[4];
  assign last_slot = idx == rsp_cap - 1'b1;
  assign len_byte  = idx >= LW'(2) && idx <= LW'(5);

  assign io_rd  = st inside {S_RDY, S_DRAIN, S_POLL, S_START, S_RDB, S_ENDM};
  assign io_wr  = st inside {S_CANCEL, S_NORMAL, S_WRB, S_EOC};
  assign io_sel = st inside {S_CANCEL, S_RDY, S_POLL, S_NORMAL, S_EOC};

  always_comb begin
    case (st)
      S_CANCEL: io_wdata = C_CANCEL;
      S_NORMAL: io_wdata = C_NORMAL;
      S_EOC:    io_wdata = C_END;
      S_WRB:    io_wdata = req_data;
      default:  io_wdata = 8'h00;
    endcase
  end

  assign req_addr  = idx;
  assign rsp_addr  = idx;
  assign rsp_we    = st == S_RDB;
  assign rsp_wdata = io_rdata;
  assign done      = done_q;
  assign err_code  = code_q;
  assign fail      = code_q != E_OK;
  assign rsp_len   = rsp_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pret      <= S_NORMAL;
      tmr       <= '0;
      idx       <= '0;
      len_q     <= '0;
      rsp_len_q <= '0;
      sts_q     <= '0;
      code_q    <= E_OK;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!(st inside {S_RDY, S_DRAIN, S_POLL})) tmr <= timeout_cycles;
      case (st)
        S_IDLE:
          if (start) begin
            if (rsp_cap < MIN_CAP) begin
              done_q <= 1'b1;
              code_q <= E_SMALL;
            end else begin
              code_q <= E_OK;
              st     <= S_CANCEL;
            end
          end
        S_CANCEL: st <= S_RDY;
        S_RDY:
          if (rdy_hit) begin
            tmr  <= timeout_cycles;
            pret <= S_NORMAL;
            st   <= S_POLL;
          end else if (tmr == '0) begin
            done_q <= 1'b1;
            code_q <= E_TMO;
            st     <= S_IDLE;
          end else begin
            tmr <= tmr - 1'b1;
            if (io_rdata[0]) st <= S_DRAIN;
          end
        S_DRAIN: st <= S_RDY;
        S_POLL:
          if (poll_hit) begin
            sts_q <= io_rdata;
            st    <= pret;
          end else if (tmr == '0) begin
            done_q <= 1'b1;
            code_q <= E_TMO;
            st     <= S_IDLE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        S_NORMAL: begin
          idx  <= '0;
          pret <= S_NEXT;
          st   <= S_POLL;
        end
        S_NEXT: begin
          pret <= (idx == req_len) ? S_EOC : S_WRB;
          st   <= S_POLL;
        end
        S_WRB: begin
          idx <= idx + 1'b1;
          st  <= S_NEXT;
        end
        S_EOC: begin
          pret <= S_START;
          st   <= S_POLL;
        end
        S_START:
          if (io_rdata != C_NORMAL) begin
            done_q <= 1'b1;
            code_q <= E_START;
            st     <= S_IDLE;
          end else begin
            idx   <= '0;
            len_q <= '0;
            pret  <= S_COLLECT;
            st    <= S_POLL;
          end
        S_COLLECT: st <= sts_q[2] ? S_ENDM : S_RDB;
        S_RDB: begin
          if (len_byte) len_q <= {len_q[23:0], io_rdata};
          if (last_slot) begin
            done_q <= 1'b1;
            code_q <= E_NOF0;
            st     <= S_IDLE;
          end else begin
            idx  <= idx + 1'b1;
            pret <= S_COLLECT;
            st   <= S_POLL;
          end
        end
        S_ENDM: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
          if (io_rdata != C_END) code_q <= E_END;
          else if (len_q > 32'(rsp_cap)) code_q <= E_OVF;
          else rsp_len_q <= len_q;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbx_xfer_seq_chk.sv
module mbx_xfer_seq_chk #(
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] rsp_cap,
  input logic          done,
  input logic [2:0]    err_code,
  input logic [31:0]   rsp_len,
  input logic          rsp_we,
  input logic [LW-1:0] rsp_addr,
  input logic          io_rd,
  input logic          io_wr,
  input logic          io_sel,
  input logic [7:0]    io_wdata
);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr));

  assert_cmd_values_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_sel) |-> (io_wdata == 8'h22 || io_wdata == 8'h01 || io_wdata == 8'h03));

  assert_cancel_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_sel && io_wdata == 8'h22) |-> $past(start));

  assert_store_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_we |-> (rsp_addr < rsp_cap));

  assert_small_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'd6) |-> ($past(start) && !$past(io_rd) && !$past(io_wr)));

  assert_len_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'd0) |-> (rsp_len <= 32'(rsp_cap)));

endmodule

bind mbx_xfer_seq mbx_xfer_seq_chk #(.LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .rsp_cap(rsp_cap), .done(done),
  .err_code(err_code), .rsp_len(rsp_len), .rsp_we(rsp_we), .rsp_addr(rsp_addr),
  .io_rd(io_rd), .io_wr(io_wr), .io_sel(io_sel), .io_wdata(io_wdata)
);

// File: tb/mbx_xfer_seq_test.sv
module mbx_xfer_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;
  localparam int TW = 16;

  typedef struct packed {
    logic [7:0]  rlen;
    logic [7:0]  cap;
    logic [7:0]  npay;
    logic [7:0]  sb;
    logic [7:0]  eb;
    logic [31:0] lenf;
    logic [3:0]  junk;
    logic [3:0]  ibfd;
    logic [7:0]  tmo;
    logic        nrdy;
    logic [2:0]  code;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd4,  8'd16, 8'd10, 8'h01, 8'h03, 32'd10, 4'd0, 4'd2, 8'd8, 1'b0, 3'd0},
    '{8'd12, 8'd32, 8'd20, 8'h01, 8'h03, 32'd20, 4'd2, 4'd4, 8'd6, 1'b0, 3'd0},
    '{8'd0,  8'd8,  8'd6,  8'h01, 8'h03, 32'd6,  4'd0, 4'd1, 8'd4, 1'b0, 3'd0},
    '{8'd3,  8'd16, 8'd8,  8'h05, 8'h03, 32'd8,  4'd0, 4'd1, 8'd4, 1'b0, 3'd2},
    '{8'd3,  8'd16, 8'd8,  8'h01, 8'h07, 32'd8,  4'd0, 4'd1, 8'd4, 1'b0, 3'd4},
    '{8'd2,  8'd16, 8'd10, 8'h01, 8'h03, 32'd17, 4'd1, 4'd1, 8'd4, 1'b0, 3'd5},
    '{8'd2,  8'd8,  8'd12, 8'h01, 8'h03, 32'd8,  4'd0, 4'd1, 8'd4, 1'b0, 3'd3},
    '{8'd2,  8'd16, 8'd8,  8'h01, 8'h03, 32'd8,  4'd0, 4'd1, 8'd5, 1'b1, 3'd1},
    '{8'd5,  8'd10, 8'd9,  8'h01, 8'h03, 32'd10, 4'd0, 4'd0, 8'd4, 1'b0, 3'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic [LW-1:0] rsp_cap = '0;
  logic [TW-1:0] timeout_cycles = '0;
  logic          done, fail;
  logic [2:0]    err_code;
  logic [31:0]   rsp_len;
  logic [LW-1:0] req_addr, rsp_addr;
  logic [7:0]    req_data, rsp_wdata, io_wdata, io_rdata;
  logic          rsp_we, io_rd, io_wr, io_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_xfer_seq #(.LW(LW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len), .rsp_cap(rsp_cap),
    .timeout_cycles(timeout_cycles), .done(done), .fail(fail), .err_code(err_code),
    .rsp_len(rsp_len), .req_addr(req_addr), .req_data(req_data), .rsp_we(rsp_we),
    .rsp_addr(rsp_addr), .rsp_wdata(rsp_wdata), .io_rd(io_rd), .io_wr(io_wr),
    .io_sel(io_sel), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  // configuration, driven by the stimulus process only
  logic [7:0] req_mem [64];
  logic [7:0] sdata [64];
  logic       smark [64];
  int         sn = 0;
  logic [3:0] cfg_junk = '0, cfg_ibfd = '0;
  logic       cfg_nrdy = 1'b0;
  logic       load = 1'b0;

  // mailbox model state
  logic       cancelled, ibr, armed;
  int         ptr, ibf_cnt, junk_left, stat_reads, viol, cmd_n, wr_n, done_cnt;
  logic [7:0] cmd_log [8];
  logic [7:0] wr_log [64];
  logic [7:0] rsp_mem [64];

  assign req_data = req_mem[req_addr[5:0]];

  logic have_rsp;
  logic [7:0] status;
  assign have_rsp = armed && (ptr < sn);
  assign status = {2'b00, ibr, cancelled && !cfg_nrdy, 1'b0,
                   (junk_left == 0) && have_rsp && smark[ptr],
                   ibf_cnt != 0, (junk_left > 0) || have_rsp};
  assign io_rdata = io_sel ? status :
                    (junk_left > 0) ? 8'hEE : have_rsp ? sdata[ptr] : 8'h00;

  always @(posedge clk) begin
    if (load) begin
      cancelled <= 1'b0; ibr <= 1'b0; armed <= 1'b0;
      ptr <= 0; ibf_cnt <= 0; junk_left <= int'(cfg_junk);
      stat_reads <= 0; viol <= 0; cmd_n <= 0; wr_n <= 0; done_cnt <= 0;
      for (int i = 0; i < 64; i++) rsp_mem[i] <= 8'h00;
    end else begin
      if (ibf_cnt != 0) ibf_cnt <= ibf_cnt - 1;
      if (done) done_cnt <= done_cnt + 1;
      if (io_wr && io_sel) begin
        if (cmd_n < 8) cmd_log[cmd_n] <= io_wdata;
        cmd_n <= cmd_n + 1;
        if (io_wdata == 8'h22) begin cancelled <= 1'b1; ibr <= 1'b0; armed <= 1'b0; end
        if (io_wdata == 8'h01) ibr <= 1'b1;
        if (io_wdata == 8'h03) begin armed <= 1'b1; ptr <= 0; end
      end
      if (io_wr && !io_sel) begin
        if (ibf_cnt != 0 || !ibr) viol <= viol + 1;
        if (wr_n < 64) wr_log[wr_n] <= io_wdata;
        wr_n <= wr_n + 1;
        ibf_cnt <= int'(cfg_ibfd);
      end
      if (io_rd && io_sel) stat_reads <= stat_reads + 1;
      if (io_rd && !io_sel) begin
        if (junk_left > 0) junk_left <= junk_left - 1;
        else if (have_rsp) ptr <= ptr + 1;
      end
      if (rsp_we) begin
        if (rsp_addr >= rsp_cap) viol <= viol + 1;
        rsp_mem[rsp_addr[5:0]] <= rsp_wdata;
      end
    end
  end

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int i, input logic [31:0] lf);
    case (i)
      2: return lf[31:24];
      3: return lf[23:16];
      4: return lf[15:8];
      5: return lf[7:0];
      default: return 8'hA0 ^ 8'(i);
    endcase
  endfunction

  task automatic setup(input vec_t v);
    for (int i = 0; i < 64; i++) req_mem[i] = 8'h30 + 8'(i * 3);
    sdata[0] = v.sb; smark[0] = 1'b1;
    for (int i = 0; i < int'(v.npay); i++) begin
      sdata[1+i] = pay(i, v.lenf); smark[1+i] = 1'b0;
    end
    sdata[v.npay+1] = v.eb; smark[v.npay+1] = 1'b1;
    sn = int'(v.npay) + 2;
    cfg_junk = v.junk; cfg_ibfd = v.ibfd; cfg_nrdy = v.nrdy;
    req_len = LW'(v.rlen); rsp_cap = LW'(v.cap); timeout_cycles = TW'(v.tmo);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_and_wait(output bit seen);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    setup(VECS[0]);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !io_rd && !io_wr && !rsp_we, "R1", "strobes idle in reset", int'({done, io_rd, io_wr, rsp_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_code == 3'd0 && !done, "R1", "code after reset", int'(err_code), 0);

    for (int n = 0; n < NV; n++) begin
      vec_t v;
      v = VECS[n];
      setup(v);
      run_and_wait(seen);
      chk(seen, "R12", "done seen", int'(seen), 1);
      chk(err_code == v.code, (v.code == 3'd1) ? "R10" : (v.code == 3'd2) ? "R5" :
          (v.code == 3'd3 || v.code == 3'd4) ? "R7" : "R9", "error code", int'(err_code), int'(v.code));
      chk(fail == (v.code != 3'd0), "R9", "fail flag", int'(fail), int'(v.code != 3'd0));
      @(negedge clk);
      chk(!done, "R12", "done width", int'(done), 0);
      chk(viol == 0, "R3", "protocol violations", viol, 0);
      if (v.code == 3'd1) begin
        chk(stat_reads == int'(v.tmo) + 1, "R10", "polls before timeout", stat_reads, int'(v.tmo) + 1);
        chk(cmd_n == 1, "R2", "commands before timeout", cmd_n, 1);
      end else begin
        chk(cmd_n == 3 && cmd_log[0] == 8'h22 && cmd_log[1] == 8'h01 && cmd_log[2] == 8'h03,
            "R2", "command order", int'(cmd_log[0]), 8'h22);
        chk(wr_n == int'(v.rlen), "R4", "request bytes written", wr_n, int'(v.rlen));
        for (int i = 0; i < int'(v.rlen); i++)
          chk(wr_log[i] == req_mem[i], "R3", "request byte", int'(wr_log[i]), int'(req_mem[i]));
      end
      if (v.junk != 0)
        chk(junk_left == 0, "R11", "stale bytes drained", junk_left, 0);
      if (v.code == 3'd0) begin
        chk(rsp_len == v.lenf, "R9", "reply length", int'(rsp_len), int'(v.lenf));
        for (int i = 0; i < int'(v.npay); i++)
          chk(rsp_mem[i] == pay(i, v.lenf), "R6", "reply byte", int'(rsp_mem[i]), int'(pay(i, v.lenf)));
        chk(rsp_mem[v.npay] == 8'h00, "R6", "no store past frame", int'(rsp_mem[v.npay]), 0);
      end
      if (v.code == 3'd3)
        chk(ptr == int'(v.cap) + 1, "R7", "reads stop at capacity", ptr, int'(v.cap) + 1);
    end

    // R8 capacity below 6
    begin
      vec_t v;
      v = VECS[0];
      v.cap = 8'd5;
      setup(v);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && err_code == 3'd6, "R8", "small capacity code", int'(err_code), 6);
      chk(cmd_n == 0 && stat_reads == 0, "R8", "no I/O on small capacity", cmd_n + stat_reads, 0);
    end

    // R12 start while busy is ignored
    begin
      setup(VECS[0]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (400) @(negedge clk);
      chk(done_cnt == 1, "R12", "one done for one transfer", done_cnt, 1);
      chk(cmd_n == 3, "R12", "no second cancel", cmd_n, 3);
      chk(err_code == 3'd0, "R12", "busy start code", int'(err_code), 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule